// File: doc/BRIEF.md
# Polarity-Selectable Phase Frequency Detector

This block compares a reference pulse train with a divided-oscillator pulse train and turns the difference between their rising edges into drive for a charge pump. Both pulse trains are asynchronous to the detector clock. A chain of flip-flops brings each one into the clock domain, and an edge detector picks out its rising edges. Each rising edge sets one of two pending flags: one for the reference and one for the feedback. Once both flags are set, a programmable delay of at least two cycles runs, and then both flags clear together. That shared hold time is the minimum correction pulse, and it keeps a dead band from forming near zero phase error. Phase error is resolved to one clock cycle.

The flags drive several outputs:
- a three-state main pump output, modelled as drive-high, drive-low and enable;
- an up-type push-pull output;
- an open-drain sink output;
- an active-low lock indicator;
- a monitor output.

The polarity input selects between the two VCO tuning slopes. It swaps the sense of every pump output, and it also steers the monitor between the synchronized reference and the synchronized feedback.

Top module: `pfd_polsel`

## Requirements
- R1: Once reset is released, and until an input edge arrives, `pump_oe`, `pump_hi`, `pump_lo`, `up_out` and `od_sink` are 0, and `lock_n` is 1.
- R2: With `slope_pos`=1 and only the reference flag pending (reference leads), the main output drives high (`pump_oe`=1, `pump_hi`=1, `pump_lo`=0). In the same state `up_out`=0 and `od_sink`=1 (`od_sink`=1 means pulling low, 0 means released).
- R3: With `slope_pos`=1 and only the feedback flag pending (reference lags), the main output drives low (`pump_oe`=1, `pump_hi`=0, `pump_lo`=1). In the same state `up_out`=1 and `od_sink`=0.
- R4: With `slope_pos`=0 the responses of R2 and R3 are swapped. Reference leading gives main low, `up_out`=1 and `od_sink`=0. Reference lagging gives main high, `up_out`=0 and `od_sink`=1.
- R5: With no flag pending, the main output is high-impedance (`pump_oe`=0, `pump_hi`=0, `pump_lo`=0), `up_out`=0 and `od_sink`=0, for either level of `slope_pos`.
- R6: `lock_n` is 0 exactly while one flag is pending and the other is not. Rising edges that reach both flags in the same cycle leave `lock_n` at 1 throughout.
- R7: A rising level on an input, driven between clock edges, sets its flag at the (SYNC_STAGES+1)-th rising clock edge after the change. The outputs reflect the flag in the cycle that follows that edge.
- R8: Once both flags are set, they stay set for exactly RST_DLY cycles (RST_DLY at least 2) and then clear together. During those cycles `pump_oe`=0, `up_out`=1, `od_sink`=1 and `lock_n`=1.
- R9: `mon_out` equals the synchronized reference level when `slope_pos`=1, and the synchronized feedback level when `slope_pos`=0. The synchronized level follows the input after SYNC_STAGES rising clock edges.
- R10: A lead of d cycles between the two input edges keeps the main output enabled for exactly d cycles before the shared hold begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Detector clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slope_pos | input | 1 | Polarity select: 1 for positive tuning slope, 0 for negative |
| ref_in | input | 1 | Reference pulse train, asynchronous |
| fb_in | input | 1 | Divided-oscillator pulse train, asynchronous |
| pump_hi | output | 1 | Main pump output, drive-high request |
| pump_lo | output | 1 | Main pump output, drive-low request |
| pump_oe | output | 1 | Main pump output enable; 0 means high-impedance |
| up_out | output | 1 | Push-pull up-type external pump output |
| od_sink | output | 1 | Open-drain output: 1 pulls low, 0 releases |
| lock_n | output | 1 | Low while a phase difference is pending |
| mon_out | output | 1 | Monitor: synchronized reference or feedback, chosen by slope_pos |

## Verification
The assertions take two things for granted.
- `slope_pos` is steady while a comparison is in flight.
- Each input stays high long enough for its flag to be set and cleared, and stays low for more than SYNC_STAGES cycles between rising edges, so no edge is missed by the synchronizer.

The stimulus keeps within these limits in three ways.
- Each comparison window raises both inputs once, at chosen cycle offsets.
- The inputs are held high until the shared hold has cleared both flags.
- Both inputs are then dropped and left idle for several cycles before the polarity changes.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  typedef struct packed {
    logic drv_hi;
    logic drv_lo;
    logic drv_en;
    logic up_o;
    logic od_sink;
    logic lock_n;
  } pump_t;

  // Polarity-aware mapping from the two pending flags to the pump outputs.
  function automatic pump_t map_pump(logic ref_f, logic fb_f, logic slope_pos);
    pump_t p;
    logic  raise_v;
    logic  lower_v;
    raise_v   = slope_pos ? ref_f : fb_f;
    lower_v   = slope_pos ? fb_f  : ref_f;
    p.drv_hi  = raise_v & ~lower_v;
    p.drv_lo  = lower_v & ~raise_v;
    p.drv_en  = raise_v ^ lower_v;
    p.up_o    = lower_v;
    p.od_sink = raise_v;
    p.lock_n  = ~(ref_f ^ fb_f);
    return p;
  endfunction

endpackage

// File: rtl/pfd_sync_edge.sv
module pfd_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic lvl,
  output logic rise
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], async_in};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign lvl  = sh_q[STAGES-1];
  assign rise = lvl & ~prev_q;

  // R7: an edge event lasts one cycle only
  a_r7_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/pfd_flags.sv
module pfd_flags #(
  parameter int RST_DLY = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_rise,
  input  logic fb_rise,
  output logic ref_f,
  output logic fb_f
);
  localparam int CW = $clog2(RST_DLY + 1);

  logic [CW-1:0] cnt_q;
  logic          both;
  logic          clr;

  assign both = ref_f & fb_f;
  assign clr  = both && (cnt_q == CW'(RST_DLY - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_f <= 1'b0;
      fb_f  <= 1'b0;
      cnt_q <= '0;
    end else begin
      // an edge landing on the clear cycle re-arms its flag
      ref_f <= clr ? ref_rise : (ref_f | ref_rise);
      fb_f  <= clr ? fb_rise  : (fb_f  | fb_rise);
      cnt_q <= both ? cnt_q + 1'b1 : '0;
    end
  end

  // R8: the shared hold lasts at least two cycles
  a_r8_min_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(both) |=> both);

  // R8: the shared hold ends once the delay count is reached
  a_r8_hold_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (both && cnt_q == CW'(RST_DLY - 1)) |=> !(ref_f && fb_f));

endmodule

// File: rtl/pfd_outmap.sv
module pfd_outmap
  import pfd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic slope_pos,
  input  logic ref_f,
  input  logic fb_f,
  input  logic ref_lvl,
  input  logic fb_lvl,
  output pump_t pump,
  output logic mon
);
  assign pump = map_pump(ref_f, fb_f, slope_pos);
  assign mon  = slope_pos ? ref_lvl : fb_lvl;

  // R5: with nothing pending, every pump output is idle
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_f && !fb_f) |-> (!pump.drv_en && !pump.up_o && !pump.od_sink));

  // R2 R3 R4: the main drive never requests both levels at once
  a_r2_drive_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(pump.drv_hi && pump.drv_lo));

endmodule

// File: rtl/pfd_polsel.sv
module pfd_polsel
  import pfd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_DLY     = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slope_pos,
  input  logic ref_in,
  input  logic fb_in,
  output logic pump_hi,
  output logic pump_lo,
  output logic pump_oe,
  output logic up_out,
  output logic od_sink,
  output logic lock_n,
  output logic mon_out
);
  localparam int NCH = 2;

  logic [NCH-1:0] raw;
  logic [NCH-1:0] lvl;
  logic [NCH-1:0] rise;
  logic           ref_f;
  logic           fb_f;
  pump_t          pump;

  assign raw = {fb_in, ref_in};

  for (genvar i = 0; i < NCH; i++) begin : g_sync
    pfd_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_in(raw[i]),
      .lvl     (lvl[i]),
      .rise    (rise[i])
    );
  end

  pfd_flags #(.RST_DLY(RST_DLY)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .ref_rise(rise[0]),
    .fb_rise (rise[1]),
    .ref_f   (ref_f),
    .fb_f    (fb_f)
  );

  pfd_outmap u_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .slope_pos(slope_pos),
    .ref_f    (ref_f),
    .fb_f     (fb_f),
    .ref_lvl  (lvl[0]),
    .fb_lvl   (lvl[1]),
    .pump     (pump),
    .mon      (mon_out)
  );

  assign pump_hi = pump.drv_hi;
  assign pump_lo = pump.drv_lo;
  assign pump_oe = pump.drv_en;
  assign up_out  = pump.up_o;
  assign od_sink = pump.od_sink;
  assign lock_n  = pump.lock_n;

  // R6: the lock indicator drops exactly when the main output is enabled
  a_r6_lock_tracks_drive: assert property (@(posedge clk) disable iff (!rst_n)
    lock_n == !pump_oe);

  // R8: in the shared hold both external outputs assert and the main output floats
  a_r8_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    (up_out && od_sink) |-> (!pump_oe && lock_n));

endmodule

// File: tb/pfd_polsel_tb.sv
`timescale 1ns/1ps
module pfd_polsel_tb;
  localparam int SYNC = 2;
  localparam int DLY  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slope_pos = 1'b1;
  logic ref_in = 1'b0;
  logic fb_in = 1'b0;
  logic pump_hi, pump_lo, pump_oe, up_out, od_sink, lock_n, mon_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  typedef struct {
    logic hi, lo, oe, up, od, lk, mon;
    string rq;
  } exp_t;

  exp_t q[$];

  always #2.5 clk = ~clk;

  pfd_polsel #(.SYNC_STAGES(SYNC), .RST_DLY(DLY)) u_dut (
    .clk(clk), .rst_n(rst_n), .slope_pos(slope_pos),
    .ref_in(ref_in), .fb_in(fb_in),
    .pump_hi(pump_hi), .pump_lo(pump_lo), .pump_oe(pump_oe),
    .up_out(up_out), .od_sink(od_sink), .lock_n(lock_n), .mon_out(mon_out)
  );

  task automatic chk(string rq, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // Monitor: samples 1 ns after every rising edge, then pops and compares
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(e.rq, "main {hi,lo,oe}", {pump_hi, pump_lo, pump_oe}, {e.hi, e.lo, e.oe});
      chk(e.rq, "external {up,od}", {up_out, od_sink}, {e.up, e.od});
      chk("R6", "lock_n", lock_n, e.lk);
      chk("R9", "mon_out", mon_out, e.mon);
    end
  end

  // Driver: raises ref at cycle tr and fb at cycle tf, and pushes the expected outputs.
  task automatic run_window(int tr, int tf, bit fc);
    int m;
    int len;
    m   = (tr > tf) ? tr : tf;
    len = m + SYNC + 1 + DLY + 2;
    @(negedge clk);
    slope_pos = fc;
    for (int c = 0; c < len; c++) begin
      exp_t e;
      int   j;
      bit   rf, ff, rl, fl;
      @(negedge clk);
      ref_in = (c >= tr);
      fb_in  = (c >= tf);
      j  = c + 1;  // the sample taken after the next rising edge
      // R7: a flag is set SYNC+1 edges after its input rises; R8: it clears DLY cycles after both are set
      rf = (j >= tr + SYNC + 1) && (j < m + SYNC + 1 + DLY);
      ff = (j >= tf + SYNC + 1) && (j < m + SYNC + 1 + DLY);
      rl = (j >= tr + SYNC);
      fl = (j >= tf + SYNC);
      if (rf && !ff) begin
        // R10: the reference leads for exactly the offset in cycles
        if (fc) begin
          e.hi = 1; e.lo = 0; e.oe = 1; e.up = 0; e.od = 1; e.rq = "R2 R7 R10";
        end else begin
          e.hi = 0; e.lo = 1; e.oe = 1; e.up = 1; e.od = 0; e.rq = "R4 R7 R10";
        end
      end else if (ff && !rf) begin
        if (fc) begin
          e.hi = 0; e.lo = 1; e.oe = 1; e.up = 1; e.od = 0; e.rq = "R3 R7 R10";
        end else begin
          e.hi = 1; e.lo = 0; e.oe = 1; e.up = 0; e.od = 1; e.rq = "R4 R7 R10";
        end
      end else if (rf && ff) begin
        e.hi = 0; e.lo = 0; e.oe = 0; e.up = 1; e.od = 1; e.rq = "R8";
      end else begin
        e.hi = 0; e.lo = 0; e.oe = 0; e.up = 0; e.od = 0; e.rq = "R5";
      end
      e.lk  = !(rf ^ ff);
      e.mon = fc ? rl : fl;
      q.push_back(e);
    end
    @(negedge clk);
    ref_in = 0;
    fb_in  = 0;
    repeat (2 * SYNC + 4) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: quiet outputs after reset
    chk("R1", "pump_oe", pump_oe, 0);
    chk("R1", "pump_hi|pump_lo", pump_hi | pump_lo, 0);
    chk("R1", "up_out", up_out, 0);
    chk("R1", "od_sink", od_sink, 0);
    chk("R1", "lock_n", lock_n, 1);

    run_window(0, 4, 1);  // R2: reference leads, positive slope
    run_window(4, 0, 1);  // R3: reference lags, positive slope
    run_window(0, 4, 0);  // R4: reference leads, negative slope
    run_window(5, 0, 0);  // R4: reference lags, negative slope
    run_window(2, 2, 1);  // R5 R6 R8: in phase, positive slope
    run_window(3, 3, 0);  // R5 R6 R8: in phase, negative slope
    run_window(0, 1, 1);  // R10: one-cycle lead
    run_window(1, 0, 0);  // R10: one-cycle lag, negative slope
    run_window(0, 9, 1);  // R10: long lead

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule